// File: doc/BRIEF.md
# Fused multiply-add NaN selector

This block decides which operand an (a*b)+c datapath should pass on when its inputs hold NaNs, or when the product is infinity times zero. It also decides whether the operation raises the invalid-operation flag. It is purely combinational and sees only summaries of the operands. Each operand arrives as a two-bit class code. A single flag says that one multiplicand is infinite and the other is zero. The datapath does the rest: it forms the product and sum, builds the NaN bit pattern and quietens a signaling NaN.

A static policy input picks one of seven propagation conventions. The conventions differ in two ways: how they treat the infinity-times-zero case, and the priority order in which they search the operands for a NaN. One convention has a sub-mode bit that reverses its search order. The result is a two-bit choice, a strobe that says the choice applies, and the invalid flag.

Top module: `fma_nan_select`

## Requirements
- R1: Class codes are 0 = not a NaN, 1 = quiet NaN, 2 = signaling NaN; code 3 counts as not a NaN. When no operand is a NaN and the infinity-times-zero flag is low, the strobe is low, the choice is 0 and invalid is low.
- R2: Choice codes are 0 = a, 1 = b, 2 = c, 3 = default NaN. Policy 0 behaves as follows:
  - With infinity-times-zero and a quiet-NaN c, it chooses 3 and raises invalid.
  - Otherwise it picks the first match among signaling c, signaling a, signaling b, quiet c, quiet a, and falls back to b.
- R3: Policy 1 chooses 3 and raises invalid whenever infinity-times-zero holds. Otherwise it picks the first match among signaling a, b, c, then quiet a, b, and falls back to c.
- R4: Policy 2 chooses c and raises invalid whenever infinity-times-zero holds. Otherwise it searches signaling NaNs in the order c, a, b, then quiet NaNs in the same order, and falls back to b.
- R5: Policy 3 chooses c and raises invalid under infinity-times-zero. Otherwise it chooses a if a is any NaN, else c if c is any NaN, else b.
- R6: Policy 4, and the unused code 7, always choose 3 while the strobe is high. They raise invalid for infinity-times-zero and for signaling NaNs only.
- R7: Policy 5 chooses c and raises invalid under infinity-times-zero. Otherwise it searches signaling NaNs in the order c, b, a, then quiet NaNs in the same order, and falls back to a.
- R8: Policy 6 chooses c and raises invalid under infinity-times-zero. Otherwise, with the sub-mode bit set, it picks the first NaN of any kind in the order a, b, c. With the bit clear, it picks the first NaN in the order c, b, a.
- R9: Invalid is high whenever any operand is a signaling NaN, under every policy.
- R10: The strobe is high exactly when some operand is a NaN or infinity-times-zero holds.
- R11: The sub-mode bit has no effect on any output under policies other than 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a_cls | input | 2 | Class code of multiplicand a |
| opnd_b_cls | input | 2 | Class code of multiplicand b |
| opnd_c_cls | input | 2 | Class code of addend c |
| inf_times_zero | input | 1 | One multiplicand is infinite and the other is zero |
| policy_sel | input | 3 | Static propagation convention |
| first_nan_mode | input | 1 | Search-order sub-mode for policy 6 |
| pick_sel | output | 2 | Chosen result source |
| pick_valid | output | 1 | A NaN or infinity-times-zero case applies |
| raise_invalid | output | 1 | Invalid-operation flag |

## Verification
The hardest situations to reach are those where two rules compete:
- infinity-times-zero combined with NaNs in several operands at once;
- the policy 0 case in which infinity-times-zero meets a c that is signaling rather than quiet, so the search order, not the default NaN, has to win.

The bench reaches all of these by sweeping every class of every operand, including the reserved code, against both flag values, every policy code and both sub-mode settings. A reference model written as plain if-chains gives the expected output for each point.

// File: rtl/fmanan_pkg.sv
package fmanan_pkg;
  localparam int CLS_W    = 2;
  localparam int SEL_W    = 2;
  localparam int POL_W    = 3;
  localparam int N_OPND   = 3;
  localparam int N_PICKER = 6;
  localparam int IDX_A    = 0;
  localparam int IDX_B    = 1;
  localparam int IDX_C    = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_NUM  = 2'd0,
    CLS_QNAN = 2'd1,
    CLS_SNAN = 2'd2,
    CLS_RSVD = 2'd3
  } opnd_cls_e;

  typedef enum logic [SEL_W-1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  // Search engines shared between policies; each is identified by its index.
  localparam int PK_CAB_SPLIT = 0;
  localparam int PK_ABC_SPLIT = 1;
  localparam int PK_CBA_SPLIT = 2;
  localparam int PK_ACB_ANY   = 3;
  localparam int PK_ABC_ANY   = 4;
  localparam int PK_CBA_ANY   = 5;

  // Operand visited at position pos (0 first) by engine e.
  function automatic int pk_order(int e, int pos);
    int ord [3];
    case (e)
      PK_CAB_SPLIT: ord = '{IDX_C, IDX_A, IDX_B};
      PK_ABC_SPLIT: ord = '{IDX_A, IDX_B, IDX_C};
      PK_CBA_SPLIT: ord = '{IDX_C, IDX_B, IDX_A};
      PK_ACB_ANY:   ord = '{IDX_A, IDX_C, IDX_B};
      PK_ABC_ANY:   ord = '{IDX_A, IDX_B, IDX_C};
      default:      ord = '{IDX_C, IDX_B, IDX_A};
    endcase
    return ord[pos];
  endfunction

  // Split engines rank signaling NaNs above quiet ones.
  function automatic bit pk_split(int e);
    return (e <= PK_CBA_SPLIT);
  endfunction
endpackage

// File: rtl/fmanan_cls_decode.sv
module fmanan_cls_decode
  import fmanan_pkg::*;
#(
  parameter int NOPND = N_OPND
) (
  input  logic [NOPND*CLS_W-1:0] cls_vec,
  output logic [NOPND-1:0]       is_qnan,
  output logic [NOPND-1:0]       is_snan
);
  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    logic [CLS_W-1:0] code;
    assign code       = cls_vec[i*CLS_W +: CLS_W];
    assign is_qnan[i] = (code == CLS_QNAN);
    assign is_snan[i] = (code == CLS_SNAN);
  end
endmodule

// File: rtl/fmanan_order_pick.sv
module fmanan_order_pick
  import fmanan_pkg::*;
#(
  parameter int ORD0  = IDX_C,
  parameter int ORD1  = IDX_A,
  parameter int ORD2  = IDX_B,
  parameter bit SPLIT = 1'b1
) (
  input  logic [N_OPND-1:0] is_qnan,
  input  logic [N_OPND-1:0] is_snan,
  output logic [SEL_W-1:0]  sel
);
  localparam logic [SEL_W-1:0] S0 = SEL_W'(ORD0);
  localparam logic [SEL_W-1:0] S1 = SEL_W'(ORD1);
  localparam logic [SEL_W-1:0] S2 = SEL_W'(ORD2);

  logic [N_OPND-1:0] is_any;
  assign is_any = is_qnan | is_snan;

  if (SPLIT) begin : g_split
    always_comb begin
      if      (is_snan[ORD0]) sel = S0;
      else if (is_snan[ORD1]) sel = S1;
      else if (is_snan[ORD2]) sel = S2;
      else if (is_qnan[ORD0]) sel = S0;
      else if (is_qnan[ORD1]) sel = S1;
      else                    sel = S2;
    end
  end else begin : g_any
    always_comb begin
      if      (is_any[ORD0]) sel = S0;
      else if (is_any[ORD1]) sel = S1;
      else                   sel = S2;
    end
  end
endmodule

// File: rtl/fmanan_policy_mux.sv
module fmanan_policy_mux
  import fmanan_pkg::*;
(
  input  logic [POL_W-1:0]                policy,
  input  logic                            first_nan,
  input  logic                            infzero,
  input  logic                            c_quiet,
  input  logic [N_PICKER-1:0][SEL_W-1:0]  picks,
  output logic [SEL_W-1:0]                sel,
  output logic                            imz_invalid
);
  always_comb begin
    sel         = PICK_DFLT;
    imz_invalid = infzero;
    case (policy)
      3'd0: begin
        imz_invalid = infzero && c_quiet;
        sel = (infzero && c_quiet) ? PICK_DFLT : picks[PK_CAB_SPLIT];
      end
      3'd1: sel = infzero ? PICK_DFLT : picks[PK_ABC_SPLIT];
      3'd2: sel = infzero ? PICK_C : picks[PK_CAB_SPLIT];
      3'd3: sel = infzero ? PICK_C : picks[PK_ACB_ANY];
      3'd5: sel = infzero ? PICK_C : picks[PK_CBA_SPLIT];
      3'd6: sel = infzero ? PICK_C
                : (first_nan ? picks[PK_ABC_ANY] : picks[PK_CBA_ANY]);
      default: sel = PICK_DFLT;
    endcase
  end
endmodule

// File: rtl/fma_nan_select.sv
module fma_nan_select
  import fmanan_pkg::*;
(
  input  logic [CLS_W-1:0] opnd_a_cls,
  input  logic [CLS_W-1:0] opnd_b_cls,
  input  logic [CLS_W-1:0] opnd_c_cls,
  input  logic             inf_times_zero,
  input  logic [POL_W-1:0] policy_sel,
  input  logic             first_nan_mode,
  output logic [SEL_W-1:0] pick_sel,
  output logic             pick_valid,
  output logic             raise_invalid
);
  logic [N_OPND-1:0]               qn, sn;
  logic [N_PICKER-1:0][SEL_W-1:0]  picks;
  logic [SEL_W-1:0]                pol_sel;
  logic                            imz_inv;

  fmanan_cls_decode #(.NOPND(N_OPND)) u_dec (
    .cls_vec (
      {opnd_c_cls, opnd_b_cls, opnd_a_cls}),
    .is_qnan (qn),
    .is_snan (sn)
  );

  for (genvar e = 0; e < N_PICKER; e++) begin : g_pick
    fmanan_order_pick #(
      .ORD0 (pk_order(e, 0)),
      .ORD1 (pk_order(e, 1)),
      .ORD2 (pk_order(e, 2)),
      .SPLIT(pk_split(e))
    ) u_pick (
      .is_qnan (qn),
      .is_snan (sn),
      .sel     (picks[e])
    );
  end

  fmanan_policy_mux u_mux (
    .policy      (policy_sel),
    .first_nan   (first_nan_mode),
    .infzero     (inf_times_zero),
    .c_quiet     (qn[IDX_C]),
    .picks       (picks),
    .sel         (pol_sel),
    .imz_invalid (imz_inv)
  );

  always_comb begin
    pick_valid    = (|qn) || (|sn) || inf_times_zero;
    raise_invalid = (|sn) || imz_inv;
    pick_sel      = pick_valid ? pol_sel : PICK_A;
  end
endmodule

// File: rtl/fma_nan_select_chk.sv
module fma_nan_select_chk
  import fmanan_pkg::*;
(
  input logic [CLS_W-1:0] opnd_a_cls,
  input logic [CLS_W-1:0] opnd_b_cls,
  input logic [CLS_W-1:0] opnd_c_cls,
  input logic             inf_times_zero,
  input logic [POL_W-1:0] policy_sel,
  input logic             first_nan_mode,
  input logic [SEL_W-1:0] pick_sel,
  input logic             pick_valid,
  input logic             raise_invalid
);
  logic known;
  logic [CLS_W-1:0] chosen_cls;

  always_comb begin
    known = !$isunknown({opnd_a_cls, opnd_b_cls, opnd_c_cls, inf_times_zero,
                         policy_sel, first_nan_mode, pick_sel, pick_valid,
                         raise_invalid});
    case (pick_sel)
      PICK_A:  chosen_cls = opnd_a_cls;
      PICK_B:  chosen_cls = opnd_b_cls;
      default: chosen_cls = opnd_c_cls;
    endcase
  end

  always_comb begin
    if (known) begin
      assert_idle_quiet_R1: assert (pick_valid || (pick_sel == PICK_A && !raise_invalid))
        else $error("idle outputs not quiet");
      assert_snan_invalid_R9: assert (!(opnd_a_cls == CLS_SNAN || opnd_b_cls == CLS_SNAN ||
                                        opnd_c_cls == CLS_SNAN) || raise_invalid)
        else $error("signaling NaN without invalid");
      assert_default_policy_R6: assert (!(pick_valid && (policy_sel == 3'd4 || policy_sel == 3'd7))
                                        || pick_sel == PICK_DFLT)
        else $error("default policy chose an operand");
      assert_infzero_addend_R4: assert (!(inf_times_zero && (policy_sel == 3'd2 || policy_sel == 3'd3 ||
                                          policy_sel == 3'd5 || policy_sel == 3'd6))
                                        || (pick_sel == PICK_C && raise_invalid))
        else $error("infzero did not select addend");
      assert_split_picks_nan_R7: assert (!(pick_valid && !inf_times_zero &&
                                           (policy_sel == 3'd1 || policy_sel == 3'd2 || policy_sel == 3'd5))
                                         || chosen_cls == CLS_QNAN || chosen_cls == CLS_SNAN)
        else $error("chosen operand is not a NaN");
    end
  end
endmodule

bind fma_nan_select fma_nan_select_chk u_chk (
  .opnd_a_cls     (opnd_a_cls),
  .opnd_b_cls     (opnd_b_cls),
  .opnd_c_cls     (opnd_c_cls),
  .inf_times_zero (inf_times_zero),
  .policy_sel     (policy_sel),
  .first_nan_mode (first_nan_mode),
  .pick_sel       (pick_sel),
  .pick_valid     (pick_valid),
  .raise_invalid  (raise_invalid)
);

// File: tb/tb_fma_nan_select.sv
module tb_fma_nan_select;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic       clk;
  logic [1:0] a_cls, b_cls, c_cls;
  logic       iz;
  logic [2:0] pol;
  logic       fmode;
  logic [1:0] sel;
  logic       vld, inv;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  fma_nan_select dut (
    .opnd_a_cls     (a_cls),
    .opnd_b_cls     (b_cls),
    .opnd_c_cls     (c_cls),
    .inf_times_zero (iz),
    .policy_sel     (pol),
    .first_nan_mode (fmode),
    .pick_sel       (sel),
    .pick_valid     (vld),
    .raise_invalid  (inv)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (a=%0d b=%0d c=%0d iz=%0d pol=%0d f=%0d)",
               tag, act, exp, a_cls, b_cls, c_cls, iz, pol, fmode);
    end
  endtask

  initial begin
    a_cls = 0; b_cls = 0; c_cls = 0; iz = 0; pol = 0; fmode = 0;
    @(negedge clk);
    for (int p = 0; p < 8; p++)
      for (int f = 0; f < 2; f++)
        for (int z = 0; z < 2; z++)
          for (int ca = 0; ca < 4; ca++)
            for (int cb = 0; cb < 4; cb++)
              for (int cc = 0; cc < 4; cc++) begin
                bit sa, sb, sc, qa, qb, qc, na, nb, nc, ev, ei;
                int es;
                string ctag;
                a_cls = 2'(ca); b_cls = 2'(cb); c_cls = 2'(cc);
                iz = 1'(z); pol = 3'(p); fmode = 1'(f);
                sa = (ca == 2); sb = (cb == 2); sc = (cc == 2);
                qa = (ca == 1); qb = (cb == 1); qc = (cc == 1);
                na = sa | qa; nb = sb | qb; nc = sc | qc;
                ev = na | nb | nc | z[0];
                ei = sa | sb | sc;
                es = 0;
                if (ev) begin
                  case (p)
                    0: if (z[0] && qc) begin es = 3; ei = 1; end
                       else es = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
                    1: if (z[0]) begin es = 3; ei = 1; end
                       else es = sa ? 0 : sb ? 1 : sc ? 2 : qa ? 0 : qb ? 1 : 2;
                    2: if (z[0]) begin es = 2; ei = 1; end
                       else es = sc ? 2 : sa ? 0 : sb ? 1 : qc ? 2 : qa ? 0 : 1;
                    3: if (z[0]) begin es = 2; ei = 1; end
                       else es = na ? 0 : nc ? 2 : 1;
                    5: if (z[0]) begin es = 2; ei = 1; end
                       else es = sc ? 2 : sb ? 1 : sa ? 0 : qc ? 2 : qb ? 1 : 0;
                    6: if (z[0]) begin es = 2; ei = 1; end
                       else if (f != 0) es = na ? 0 : nb ? 1 : 2;
                       else es = nc ? 2 : nb ? 1 : 0;
                    default: begin es = 3; ei = ei | z[0]; end
                  endcase
                end
                case (p)
                  0: ctag = "R2";
                  1: ctag = "R3";
                  2: ctag = "R4";
                  3: ctag = "R5";
                  5: ctag = "R7";
                  6: ctag = "R8";
                  default: ctag = "R6";
                endcase
                if (!ev) ctag = "R1";
                else if (f != 0 && p != 6) ctag = {ctag, "/R11"};
                #(CLK_PERIOD/2);
                check({ctag, " choice"}, int'(sel), es);
                check(ev ? "R10 strobe" : "R1 strobe", int'(vld), int'(ev));
                check(ei && (sa | sb | sc) ? "R9 invalid" : {ctag, " invalid"},
                      int'(inv), int'(ei));
                @(negedge clk);
              end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule